// File: doc/BRIEF.md
# Byte-Access Engine for ECC-Protected Word Storage

This block connects a byte-wide request port to a storage array whose unit is a 32-bit word kept with 6 Hamming check bits (a 38-bit codeword). Every stored word is protected as a whole, so a request that touches one byte still has to deal with the whole word. A byte read fetches the codeword, repairs any single flipped bit, and returns the selected byte with a flag that says whether a repair took place. A byte write fetches the codeword, repairs it, replaces one byte, computes the check bits again and stores all 38 bits. A full word write skips the fetch and stores a freshly encoded codeword straight away.

The array is outside the block. It is a synchronous register file: a read enable in one cycle yields the codeword in the next cycle. The engine holds one request at a time. It runs through the states IDLE, READ, CORRECT_MERGE, ENCODE, WRITE and DONE. The transitions are:
- IDLE or DONE to READ, on an accepted byte read or byte write.
- IDLE or DONE to ENCODE, on an accepted full word write.
- READ to CORRECT_MERGE, always.
- CORRECT_MERGE to DONE for a read, and to ENCODE for a byte write.
- ENCODE to WRITE, then WRITE to DONE.
- IDLE or DONE to IDLE, when no request is present.

Top module: `ecc_rmw_engine`

## Requirements
- R1: After reset, `busy`, `op_done`, `rd_valid`, `err_corr`, `err_uncorr`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: A stored codeword places codeword position p (1 to 38) at bit p-1. Check bits sit at positions 1, 2, 4, 8, 16 and 32. The check bit at position 2^j is the even parity of all other positions that have bit j set. The data bits 0 to 31 fill the remaining positions in ascending order.
- R3: A full word write (`req_write`=1, `req_full`=1) issues no array read. It stores the encoded `req_wdata` with one `mem_wr_en` pulse and ignores `req_addr[1:0]`.
- R4: A byte write (`req_write`=1, `req_full`=0) issues one array read and one array write. The stored word equals the repaired old word with bits [8*lane+7:8*lane] replaced by `req_wdata[7:0]`, where lane is `req_addr[1:0]`. The other three lanes are kept.
- R5: A read (`req_write`=0) returns byte lane `req_addr[1:0]` of the repaired word on `rd_data`. `rd_valid` is high in the same cycle as `op_done`.
- R6: A syndrome from 1 to 38 flips that codeword position. `err_corr` is then high for exactly one cycle, in the `op_done` cycle. This holds for reads and for byte writes.
- R7: A nonzero syndrome above 38 raises `err_uncorr` for the `op_done` cycle. In that case the data bits are passed on unrepaired and `err_corr` stays low.
- R8: A read never drives `mem_wr_en`. A repaired word is not written back, so a second read of that word again reports `err_corr`.
- R9: `busy` is high from the cycle after acceptance until DONE and is low in IDLE and DONE. Requests are taken only in IDLE or DONE. A request presented while `busy` is high has no effect.
- R10: `req_addr[13:2]` selects the array word on `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | With req_write: whole aligned word write |
| req_addr | input | 14 | Byte address: [13:2] word, [1:0] lane |
| req_wdata | input | 32 | Word data for full writes; [7:0] is the byte for byte writes |
| busy | output | 1 | Engine occupied, requests not taken |
| op_done | output | 1 | One-cycle completion strobe |
| rd_valid | output | 1 | rd_data valid (read completion) |
| rd_data | output | 8 | Returned byte |
| err_corr | output | 1 | Single-bit error was repaired |
| err_uncorr | output | 1 | Syndrome out of range, data not repaired |
| mem_rd_en | output | 1 | Array read enable |
| mem_wr_en | output | 1 | Array write enable |
| mem_addr | output | 12 | Array word address |
| mem_wr_data | output | 38 | Codeword to store |
| mem_rd_data | input | 38 | Codeword read, valid the cycle after mem_rd_en |

## Verification
The DONE state does two jobs in the same cycle. It presents the result of the finished operation on `rd_data`, `err_corr` and `err_uncorr`, and it accepts the next request. The bench provokes this by issuing operations back to back: its driver presents a new request as soon as `busy` drops, so the acceptance lands exactly in the DONE cycle of the previous read. The scoreboard then has to see the earlier read's byte and flags intact, and the following operation must still complete with its own correct result and stored codeword.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CORRECT_MERGE,
        ST_ENCODE,
        ST_WRITE,
        ST_DONE
    } rmw_state_e;

    typedef enum logic [1:0] {
        OP_READ,
        OP_BYTE_WR,
        OP_WORD_WR
    } rmw_op_e;

endpackage

// File: rtl/ecc_hamming_enc.sv
module ecc_hamming_enc #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 6
) (
    input  logic [DATA_W-1:0]       data_in,
    output logic [DATA_W+CHK_W-1:0] code_out
);
    localparam int CODE_W = DATA_W + CHK_W;

    always_comb begin
        int k;
        logic par;
        code_out = '0;
        k = 0;
        // data bits fill non-power-of-two positions in ascending order
        for (int p = 1; p <= CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                code_out[p-1] = data_in[k];
                k++;
            end
        end
        // check bit at 2^j covers positions with bit j set
        for (int j = 0; j < CHK_W; j++) begin
            par = 1'b0;
            for (int p = 1; p <= CODE_W; p++) begin
                if (p[j]) par = par ^ code_out[p-1];
            end
            code_out[(1 << j) - 1] = par;
        end
    end
endmodule

// File: rtl/ecc_hamming_dec.sv
module ecc_hamming_dec #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 6
) (
    input  logic [DATA_W+CHK_W-1:0] code_in,
    output logic [DATA_W-1:0]       data_out,
    output logic                    fixed,
    output logic                    unfixable
);
    localparam int CODE_W = DATA_W + CHK_W;

    logic [CHK_W-1:0]  syndrome;
    logic [CODE_W-1:0] repaired;

    always_comb begin
        int k;
        syndrome = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (code_in[p-1]) syndrome = syndrome ^ p[CHK_W-1:0];
        end

        repaired  = code_in;
        fixed     = 1'b0;
        unfixable = (syndrome != '0);
        for (int p = 1; p <= CODE_W; p++) begin
            if (syndrome == p[CHK_W-1:0]) begin
                repaired[p-1] = ~code_in[p-1];
                fixed         = 1'b1;
                unfixable     = 1'b0;
            end
        end

        data_out = '0;
        k = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                data_out[k] = repaired[p-1];
                k++;
            end
        end
    end
endmodule

// File: rtl/ecc_rmw_engine.sv
module ecc_rmw_engine
    import ecc_rmw_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 32,
    parameter int CHK_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_full,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    busy,
    output logic                    op_done,
    output logic                    rd_valid,
    output logic [7:0]              rd_data,
    output logic                    err_corr,
    output logic                    err_uncorr,
    output logic                    mem_rd_en,
    output logic                    mem_wr_en,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
    output logic [DATA_W+CHK_W-1:0] mem_wr_data,
    input  logic [DATA_W+CHK_W-1:0] mem_rd_data
);
    localparam int CODE_W  = DATA_W + CHK_W;
    localparam int LANES   = DATA_W / 8;
    localparam int LANE_W  = $clog2(LANES);
    localparam int WORD_AW = ADDR_W - LANE_W;

    rmw_state_e          state, state_nx;
    rmw_op_e             op_q;
    logic [WORD_AW-1:0]  word_q;
    logic [LANE_W-1:0]   lane_q;
    logic [7:0]          byte_q;
    logic [DATA_W-1:0]   data_q;
    logic [CODE_W-1:0]   code_q;
    logic                corr_q, unc_q;

    logic [DATA_W-1:0]   dec_data, merged;
    logic                dec_fixed, dec_unfixable;
    logic [CODE_W-1:0]   enc_code;
    logic                accept;

    ecc_hamming_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
        .code_in   (mem_rd_data),
        .data_out  (dec_data),
        .fixed     (dec_fixed),
        .unfixable (dec_unfixable)
    );

    ecc_hamming_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
        .data_in  (data_q),
        .code_out (enc_code)
    );

    assign accept = req_valid && (state == ST_IDLE || state == ST_DONE);

    always_comb begin
        merged = dec_data;
        if (op_q == OP_BYTE_WR) merged[lane_q*8 +: 8] = byte_q;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (!req_valid)                  state_nx = ST_IDLE;
                else if (req_write && req_full)  state_nx = ST_ENCODE;
                else                             state_nx = ST_READ;
            end
            ST_READ:          state_nx = ST_CORRECT_MERGE;
            ST_CORRECT_MERGE: state_nx = (op_q == OP_READ) ? ST_DONE : ST_ENCODE;
            ST_ENCODE:        state_nx = ST_WRITE;
            ST_WRITE:         state_nx = ST_DONE;
            default:          state_nx = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_READ;
            word_q <= '0;
            lane_q <= '0;
            byte_q <= '0;
            data_q <= '0;
            code_q <= '0;
            corr_q <= 1'b0;
            unc_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                op_q   <= !req_write ? OP_READ : (req_full ? OP_WORD_WR : OP_BYTE_WR);
                word_q <= req_addr[ADDR_W-1:LANE_W];
                lane_q <= req_addr[LANE_W-1:0];
                byte_q <= req_wdata[7:0];
                data_q <= req_wdata;
                corr_q <= 1'b0;
                unc_q  <= 1'b0;
            end
            if (state == ST_CORRECT_MERGE) begin
                data_q <= merged;
                corr_q <= dec_fixed;
                unc_q  <= dec_unfixable;
            end
            if (state == ST_ENCODE) code_q <= enc_code;
        end
    end

    // outputs
    always_comb begin
        busy        = !(state == ST_IDLE || state == ST_DONE);
        op_done     = (state == ST_DONE);
        rd_valid    = (state == ST_DONE) && (op_q == OP_READ);
        rd_data     = data_q[lane_q*8 +: 8];
        err_corr    = (state == ST_DONE) && corr_q;
        err_uncorr  = (state == ST_DONE) && unc_q;
        mem_rd_en   = (state == ST_READ);
        mem_wr_en   = (state == ST_WRITE);
        mem_addr    = word_q;
        mem_wr_data = code_q;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> !busy && !mem_rd_en && !mem_wr_en && !op_done);
    a_r8_read_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_READ) |-> !mem_wr_en);
    a_r3_word_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_WORD_WR) |-> !mem_rd_en);
    a_r4_merge_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CORRECT_MERGE) |-> $past(mem_rd_en));
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_corr, err_uncorr}));
    a_r6_corr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_corr |=> !err_corr);
    a_r9_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> op_done);
    a_r9_free_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !busy);
    a_r5_result_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> op_done);
endmodule

// File: tb/ecc_rmw_engine_tb.sv
module ecc_rmw_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_full = 1'b0;
    logic [13:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, op_done, rd_valid, err_corr, err_uncorr, mem_rd_en, mem_wr_en;
    logic [7:0]  rd_data;
    logic [11:0] mem_addr;
    logic [37:0] mem_wr_data;
    logic [37:0] mem_rd_data;

    always #2.5 clk = ~clk;

    ecc_rmw_engine u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_full(req_full), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .op_done(op_done), .rd_valid(rd_valid), .rd_data(rd_data),
        .err_corr(err_corr), .err_uncorr(err_uncorr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wr_data(mem_wr_data),
        .mem_rd_data(mem_rd_data)
    );

    // array model: synchronous read, one-cycle latency
    logic [37:0] mem [4096];
    logic [31:0] model [4096];
    int rd_cnt = 0, wr_cnt = 0;
    initial begin
        for (int i = 0; i < 4096; i++) begin mem[i] = '0; model[i] = '0; end
        mem_rd_data = '0;
    end
    always @(posedge clk) begin
        if (mem_rd_en) begin mem_rd_data <= mem[mem_addr]; rd_cnt++; end
        if (mem_wr_en) begin mem[mem_addr] <= mem_wr_data; wr_cnt++; end
    end

    int checks = 0, errors = 0;
    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // codeword built from the layout rule (R2)
    function automatic logic [37:0] encode(input logic [31:0] d);
        logic [37:0] c;
        int k;
        c = '0; k = 0;
        for (int pos = 1; pos <= 38; pos++)
            if ($countones(pos) != 1) begin c[pos-1] = d[k]; k++; end
        for (int j = 0; j < 6; j++) begin
            logic s;
            s = 1'b0;
            for (int pos = 1; pos <= 38; pos++)
                if (((pos >> j) & 1) == 1 && pos != (1 << j)) s ^= c[pos-1];
            c[(1 << j) - 1] = s;
        end
        return c;
    endfunction

    typedef struct {
        bit         is_read;
        logic [7:0] byte_v;
        bit         corr;
        bit         unc;
        string      tag;
    } exp_t;
    exp_t sb[$];
    int done_cnt = 0;

    task automatic issue(input bit wr, input bit full, input int word, input int lane,
                         input logic [31:0] wd, input bit ec, input bit eu,
                         input logic [7:0] eb, input string tag);
        exp_t e;
        while (busy) @(negedge clk);
        e.is_read = !wr; e.byte_v = eb; e.corr = ec; e.unc = eu; e.tag = tag;
        sb.push_back(e);
        req_valid = 1'b1; req_write = wr; req_full = full;
        req_addr = {word[11:0], lane[1:0]}; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: compare each completion with the head of the queue
    always @(negedge clk) begin
        if (rst_n && op_done) begin
            done_cnt++;
            if (sb.size() == 0) begin
                check(0, "R9 unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rd_valid == e.is_read, {e.tag, " rd_valid R5"}, rd_valid, e.is_read);
                if (e.is_read) check(rd_data == e.byte_v, {e.tag, " data R5"}, rd_data, e.byte_v);
                check(err_corr == e.corr, {e.tag, " corr R6"}, err_corr, e.corr);
                check(err_uncorr == e.unc, {e.tag, " uncorr R7"}, err_uncorr, e.unc);
                check(!busy, {e.tag, " busy at done R9"}, busy, 0);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int r0, w0, d0;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !op_done && !rd_valid && !err_corr && !err_uncorr && !mem_rd_en && !mem_wr_en,
              "R1 reset outputs", {busy, op_done, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R2 full word write, nonzero lane bits ignored
        r0 = rd_cnt; w0 = wr_cnt;
        model[5] = 32'hA5C3_0F81;
        issue(1, 1, 5, 3, model[5], 0, 0, 0, "word write");
        drain();
        check(mem[5] == encode(model[5]), "R2 R3 stored codeword", mem[5], encode(model[5]));
        check(rd_cnt == r0 && wr_cnt == w0 + 1, "R3 no read, one write", rd_cnt - r0, 0);

        // R5/R10 read each lane, back-to-back (acceptance in DONE)
        for (int l = 0; l < 4; l++)
            issue(0, 0, 5, l, 0, 0, 0, model[5][l*8 +: 8], "lane read");
        drain();

        // R9 busy after acceptance, request while busy ignored
        r0 = rd_cnt; w0 = wr_cnt; d0 = done_cnt;
        issue(0, 0, 5, 0, 0, 0, 0, model[5][7:0], "read before ignore");
        check(busy, "R9 busy after acceptance", busy, 1);
        req_valid = 1'b1; req_write = 1'b1; req_full = 1'b1;
        req_addr = {12'd20, 2'd0}; req_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        repeat (4) @(negedge clk);
        check(mem[20] == '0, "R9 busy request ignored", mem[20], 0);
        check(done_cnt == d0 + 1 && wr_cnt == w0, "R9 single completion", done_cnt - d0, 1);

        // R4 byte write into lane 2
        r0 = rd_cnt; w0 = wr_cnt;
        model[5][23:16] = 8'h3C;
        issue(1, 0, 5, 2, 32'h0000_003C, 0, 0, 0, "byte write");
        drain();
        check(mem[5] == encode(model[5]), "R4 merged word stored", mem[5], encode(model[5]));
        check(rd_cnt == r0 + 1 && wr_cnt == w0 + 1, "R4 one read one write", rd_cnt - r0, 1);

        // R6/R8 single data-bit error, read twice without write-back
        mem[5][10] = ~mem[5][10];
        v = model[5];
        w0 = wr_cnt;
        issue(0, 0, 5, 1, 0, 1, 0, v[15:8], "corrected read");
        issue(0, 0, 5, 2, 0, 1, 0, v[23:16], "second corrected read");
        drain();
        check(wr_cnt == w0, "R8 no write-back on read", wr_cnt - w0, 0);
        check(mem[5] != encode(model[5]), "R8 array still holds error", 0, 1);

        // R6 byte write over a corrupted word repairs and stores clean
        model[5][7:0] = 8'h5A;
        issue(1, 0, 5, 0, 32'h0000_005A, 1, 0, 0, "byte write over error");
        drain();
        check(mem[5] == encode(model[5]), "R6 R4 repaired merge stored", mem[5], encode(model[5]));

        // R6 check-bit error (position 1) at word 4095
        model[4095] = 32'h1357_9BDF;
        issue(1, 1, 4095, 0, model[4095], 0, 0, 0, "word write top");
        drain();
        mem[4095][0] = ~mem[4095][0];
        issue(0, 0, 4095, 3, 0, 1, 0, model[4095][31:24], "check-bit error read R10");

        // R7 double error: positions 7 and 32 give syndrome 39
        model[9] = 32'h0F0F_F0F0;
        issue(1, 1, 9, 0, model[9], 0, 0, 0, "word write 9");
        drain();
        mem[9][6] = ~mem[9][6];
        mem[9][31] = ~mem[9][31];
        issue(0, 0, 9, 0, 0, 0, 1, model[9][7:0] ^ 8'h08, "uncorrectable read");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule